// File: doc/BRIEF.md
# Beverage Vending Controller with Running Bill

This block is the sequencing core of a three-drink vending machine. A customer picks tea, coffee or milk on a one-hot select input. If the machine reports that the drink is in stock, the controller waits for payment. Coin pulses worth 1, 2 and 5 units are added to a credit register. Once the credit covers the price, the controller raises a one-cycle dispense strobe for the drink and presents any overpayment on a change output in that same cycle. A cancel request made while payment is pending returns the whole credit on a refund output. A running bill adds up the prices of all drinks delivered since reset. If a drink is selected while stock is missing, the controller locks into a service state that only reset can clear.

The four control states are held one-hot in three replicated copies. On every clock edge a bitwise majority vote repairs a single corrupted copy, and the repaired vector is written back to all copies. An error flag reports any disagreement among the copies, and also a voted vector that is not one-hot. A vector that is not one-hot is treated as the selection state. An upset input XORs a mask into the copies as they are written, so that corruption can be injected on purpose. Prices and widths are parameters.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, phase is selection (4'b0001), and dispense, change, refund, bill, service and state_err are all zero.
- R2: In the selection phase, a select value with exactly one bit set (bit0 tea, bit1 coffee, bit2 milk) while avail is high moves the phase to waiting (4'b0010) after one edge. A select value of zero or with two or more bits set is ignored, and so are coins inserted during selection.
- R3: A valid select while avail is low moves the phase to service (4'b1000) and raises service. The controller then ignores select, coins and cancel until reset.
- R4: In the waiting phase, coin_1, coin_2 and coin_5 present in the same cycle are added together with the stored credit. The result saturates at 2^W-1 (127 by default).
- R5: When the sum from R4 reaches at least the price of the chosen drink (tea 3, coffee 4, milk 5 by default), dispense shows the drink's select bit for exactly one cycle, together with change = sum - price. The phase is delivery (4'b0100) in that cycle.
- R6: A cancel in the waiting phase puts the sum from R4, including coins of the same cycle, on refund for one cycle. It dispenses nothing, leaves the bill unchanged and returns to selection. Cancel takes precedence over a payment that would complete in the same cycle.
- R7: The bill increases by the price of each delivered drink in the cycle its dispense strobe shows. It saturates at 2^W-1, is never decreased, and is cleared only by reset.
- R8: An upset mask with a single bit set, applied at an edge, raises state_err in the following cycle. Phase and transactions continue exactly as without the upset, and state_err clears one cycle later.
- R9: If two copies are corrupted so that the voted vector is not one-hot, state_err rises, the phase is forced to selection, and the pending credit is discarded.
- R10: The delivery phase lasts one cycle and is always followed by selection. A select held during the delivery cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Drink choice, one-hot: bit0 tea, bit1 coffee, bit2 milk |
| coin_1 | input | 1 | Coin pulse worth 1 unit |
| coin_2 | input | 1 | Coin pulse worth 2 units |
| coin_5 | input | 1 | Coin pulse worth 5 units |
| avail | input | 1 | Stock present for the selected drink |
| cancel | input | 1 | Customer abort request |
| upset | input | NREP*4 | XOR mask on the state copies as they are written; copy r, state bit b at index r*4+b |
| dispense | output | 3 | One-cycle strobe carrying the delivered drink's select bit |
| change | output | W | Overpayment, valid while dispense is non-zero, else zero |
| refund | output | W | Returned credit for one cycle after cancel, else zero |
| bill | output | W | Saturating total price of drinks delivered since reset |
| phase | output | 4 | Repaired one-hot state: selection, waiting, delivery, service |
| service | output | 1 | High in the service lockout state |
| state_err | output | 1 | State copies disagree, or the vote is not one-hot |

## Verification
Two functions collide in one cycle: cancel, and a coin that completes the payment. The bench drives cancel together with every coin combination after a 1-unit deposit, for each drink. It requires a refund equal to the full sum, no strobe and an unchanged bill, even where the sum exceeds the price. A second collision joins a state-copy upset with a live payment. The bench flips one copy while coins are being added and requires the later delivery and change to match the undisturbed arithmetic. It also flips two copies and requires a forced return to selection with the credit discarded.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int NST = 4;

    typedef logic [NST-1:0] st_vec_t;

    localparam st_vec_t ST_SEL   = 4'b0001;
    localparam st_vec_t ST_WAIT  = 4'b0010;
    localparam st_vec_t ST_DELIV = 4'b0100;
    localparam st_vec_t ST_SVC   = 4'b1000;

    function automatic logic vec_onehot(st_vec_t v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic pick_single(logic [2:0] s);
        return (s == 3'b001) || (s == 3'b010) || (s == 3'b100);
    endfunction

endpackage

// File: rtl/vend_state_reg.sv
module vend_state_reg
    import vend_pkg::*;
#(
    parameter int NREP = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  st_vec_t               nxt,
    input  logic [NREP*NST-1:0]   upset,
    output st_vec_t               cur,
    output logic                  err
);
    localparam int HALF = NREP / 2;

    st_vec_t copies [NREP];
    st_vec_t voted;
    logic    differ;

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREP; r++) begin
            if (rst) copies[r] <= ST_SEL;
            else     copies[r] <= nxt ^ upset[r*NST +: NST];
        end
    end

    always_comb begin
        differ = 1'b0;
        for (int b = 0; b < NST; b++) begin
            int cnt;
            cnt = 0;
            for (int r = 0; r < NREP; r++) cnt = cnt + int'(copies[r][b]);
            voted[b] = (cnt > HALF);
        end
        for (int r = 1; r < NREP; r++) begin
            if (copies[r] != copies[0]) differ = 1'b1;
        end
    end

    assign cur = vec_onehot(voted) ? voted : ST_SEL;
    assign err = differ | ~vec_onehot(voted);

endmodule

// File: rtl/vend_credit.sv
module vend_credit #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         keep,
    input  logic         c1,
    input  logic         c2,
    input  logic         c5,
    output logic [W-1:0] sum
);
    localparam logic [W+1:0] CAP = {2'b00, {W{1'b1}}};

    logic [W-1:0] credit;
    logic [W+1:0] wide;

    always_comb begin
        wide = {2'b00, credit}
             + {{(W+1){1'b0}}, c1}
             + {{W{1'b0}}, c2, 1'b0}
             + {{(W-1){1'b0}}, c5, 1'b0, c5};
        sum  = (wide > CAP) ? {W{1'b1}} : wide[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !keep) credit <= '0;
        else              credit <= sum;
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int W            = 7,
    parameter int NREP         = 3,
    parameter int PRICE_TEA    = 3,
    parameter int PRICE_COFFEE = 4,
    parameter int PRICE_MILK   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           sel,
    input  logic                 coin_1,
    input  logic                 coin_2,
    input  logic                 coin_5,
    input  logic                 avail,
    input  logic                 cancel,
    input  logic [NREP*NST-1:0]  upset,
    output logic [2:0]           dispense,
    output logic [W-1:0]         change,
    output logic [W-1:0]         refund,
    output logic [W-1:0]         bill,
    output logic [NST-1:0]       phase,
    output logic                 service,
    output logic                 state_err
);
    localparam logic [W-1:0] P_TEA = W'(PRICE_TEA);
    localparam logic [W-1:0] P_COF = W'(PRICE_COFFEE);
    localparam logic [W-1:0] P_MLK = W'(PRICE_MILK);

    st_vec_t      cur, nxt;
    logic         keep, do_vend, do_back, take_sel;
    logic [2:0]   prod;
    logic [W-1:0] price, sum;
    logic [W:0]   bsum;

    vend_state_reg #(.NREP(NREP)) u_state (
        .clk(clk), .rst(rst), .nxt(nxt), .upset(upset),
        .cur(cur), .err(state_err)
    );

    vend_credit #(.W(W)) u_credit (
        .clk(clk), .rst(rst), .keep(keep),
        .c1(coin_1), .c2(coin_2), .c5(coin_5), .sum(sum)
    );

    always_comb begin
        case (prod)
            3'b001:  price = P_TEA;
            3'b010:  price = P_COF;
            default: price = P_MLK;
        endcase
    end

    always_comb begin
        nxt      = cur;
        keep     = 1'b0;
        do_vend  = 1'b0;
        do_back  = 1'b0;
        take_sel = 1'b0;
        case (cur)
            ST_SEL: begin
                if (pick_single(sel)) begin
                    take_sel = 1'b1;
                    nxt      = avail ? ST_WAIT : ST_SVC;
                end
            end
            ST_WAIT: begin
                if (cancel) begin
                    do_back = 1'b1;
                    nxt     = ST_SEL;
                end else if (sum >= price) begin
                    do_vend = 1'b1;
                    nxt     = ST_DELIV;
                end else begin
                    keep    = 1'b1;
                end
            end
            ST_DELIV: nxt = ST_SEL;
            ST_SVC:   nxt = ST_SVC;
            default:  nxt = ST_SEL;
        endcase
    end

    assign bsum = {1'b0, bill} + {1'b0, price};

    always_ff @(posedge clk) begin
        if (rst) begin
            prod     <= 3'b001;
            dispense <= '0;
            change   <= '0;
            refund   <= '0;
            bill     <= '0;
        end else begin
            if (take_sel) prod <= sel;
            dispense <= do_vend ? prod : 3'b000;
            change   <= do_vend ? (sum - price) : '0;
            refund   <= do_back ? sum : '0;
            if (do_vend) bill <= bsum[W] ? {W{1'b1}} : bsum[W-1:0];
        end
    end

    assign phase   = cur;
    assign service = (cur == ST_SVC);

endmodule

// File: rtl/vend_chk.sv
module vend_chk
    import vend_pkg::*;
#(
    parameter int W    = 7,
    parameter int NREP = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [NREP*NST-1:0] upset,
    input logic [2:0]          dispense,
    input logic [W-1:0]        refund,
    input logic [W-1:0]        bill,
    input logic [NST-1:0]      phase,
    input logic                service,
    input logic                state_err
);
    assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dispense));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        (dispense != 3'b000) |=> (dispense == 3'b000));

    assert_service_locked_R3: assert property (@(posedge clk) disable iff (rst)
        service |=> service);

    assert_refund_no_vend_R6: assert property (@(posedge clk) disable iff (rst)
        (refund != '0) |-> (dispense == 3'b000));

    assert_bill_monotone_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bill >= $past(bill)));

    assert_flip_flagged_R8: assert property (@(posedge clk) disable iff (rst)
        ($countones(upset) == 1) |=> state_err);

    assert_phase_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase));

    assert_deliv_to_sel_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_DELIV) |=> (phase == ST_SEL));

endmodule

bind vend_ctrl vend_chk #(.W(W), .NREP(NREP)) u_chk (
    .clk(clk), .rst(rst), .upset(upset), .dispense(dispense),
    .refund(refund), .bill(bill), .phase(phase), .service(service),
    .state_err(state_err)
);

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;

    localparam int W = 7;
    localparam int NREP = 3;
    localparam int UW = NREP * 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] sel = '0;
    logic c1 = 0, c2 = 0, c5 = 0, avail = 1, cancel = 0;
    logic [UW-1:0] upset = '0;

    logic [2:0] disp, disp_b;
    logic [W-1:0] chg, chg_b, rfd, rfd_b, bill, bill_b;
    logic [3:0] ph, ph_b;
    logic svc, svc_b, err, err_b;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    vend_ctrl #(.W(W), .NREP(NREP)) dut (
        .clk(clk), .rst(rst), .sel(sel), .coin_1(c1), .coin_2(c2), .coin_5(c5),
        .avail(avail), .cancel(cancel), .upset(upset),
        .dispense(disp), .change(chg), .refund(rfd), .bill(bill),
        .phase(ph), .service(svc), .state_err(err)
    );

    vend_ctrl #(.W(W), .NREP(NREP), .PRICE_TEA(100), .PRICE_COFFEE(120),
                .PRICE_MILK(127)) dut_big (
        .clk(clk), .rst(rst), .sel(sel), .coin_1(c1), .coin_2(c2), .coin_5(c5),
        .avail(avail), .cancel(cancel), .upset(upset),
        .dispense(disp_b), .change(chg_b), .refund(rfd_b), .bill(bill_b),
        .phase(ph_b), .service(svc_b), .state_err(err_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        sel = '0; c1 = 0; c2 = 0; c5 = 0; cancel = 0; upset = '0; avail = 1;
    endtask

    function automatic int coin_val(input int m);
        return (m & 1) + ((m >> 1) & 1) * 2 + ((m >> 2) & 1) * 5;
    endfunction

    task automatic put_coins(input int m);
        c1 = m[0]; c2 = m[1]; c5 = m[2];
    endtask

    task automatic do_reset();
        rst = 1; idle_in();
        tick(); tick();
        rst = 0;
        tick();
    endtask

    int prices[3] = '{3, 4, 5};
    int exp_bill = 0;

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        chk("R1 phase in reset", int'(ph), 1);
        chk("R1 bill in reset", int'(bill), 0);
        rst = 0;
        tick();
        chk("R1 phase", int'(ph), 1);
        chk("R1 outputs", int'({disp, chg, rfd, bill, svc, err}), 0);

        // R2: invalid selects and coins in selection are ignored
        sel = 3'b011; tick();
        chk("R2 multi select ignored", int'(ph), 1);
        sel = 3'b111; tick();
        chk("R2 all select ignored", int'(ph), 1);
        sel = 3'b000; c5 = 1; tick();
        chk("R2 idle coins", int'(ph), 1);
        idle_in(); sel = 3'b001; tick(); sel = 0;
        chk("R2 tea accepted", int'(ph), 2);
        c2 = 1; tick(); c2 = 0;
        chk("R2 earlier coins not credited", int'(disp), 0);
        chk("R2 still waiting", int'(ph), 2);
        c1 = 1; tick(); c1 = 0;
        chk("R5 tea at 3", int'(disp), 1);
        chk("R5 change zero", int'(chg), 0);
        exp_bill += 3;
        chk("R7 bill", int'(bill), exp_bill);
        sel = 3'b010; tick(); sel = 0;
        chk("R10 select in delivery ignored", int'(ph), 1);
        chk("R10 strobe one cycle", int'(disp), 0);

        // R4/R5/R7/R10: sweep of product and coin pattern
        for (int p = 0; p < 3; p++) begin
            for (int m = 1; m < 8; m++) begin
                int cr;
                cr = 0;
                sel = 3'(1 << p); tick(); sel = 0;
                chk("R2 waiting", int'(ph), 2);
                for (int it = 0; it < 10; it++) begin
                    int s;
                    s = cr + coin_val(m);
                    put_coins(m); tick(); put_coins(0);
                    if (s >= prices[p]) begin
                        exp_bill += prices[p];
                        chk("R5 dispense", int'(disp), 1 << p);
                        chk("R5 change", int'(chg), s - prices[p]);
                        chk("R7 bill", int'(bill), exp_bill);
                        chk("R5 delivery phase", int'(ph), 4);
                        tick();
                        chk("R10 back to select", int'(ph), 1);
                        chk("R10 strobe cleared", int'(disp), 0);
                        break;
                    end
                    chk("R4 no early dispense", int'(disp), 0);
                    cr = s;
                end
            end
        end

        // R6: cancel against every coin pattern, cancel wins
        for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 8; m++) begin
                sel = 3'(1 << p); tick(); sel = 0;
                c1 = 1; tick(); c1 = 0;
                put_coins(m); cancel = 1; tick(); put_coins(0); cancel = 0;
                chk("R6 refund sum", int'(rfd), 1 + coin_val(m));
                chk("R6 no dispense", int'(disp), 0);
                chk("R6 bill kept", int'(bill), exp_bill);
                chk("R6 to select", int'(ph), 1);
                tick();
                chk("R6 refund pulse", int'(rfd), 0);
            end
        end

        // R8: single copy flip, in selection and during payment
        upset = UW'(1) << 4; tick(); upset = '0;
        chk("R8 err raised", int'(err), 1);
        chk("R8 phase kept", int'(ph), 1);
        tick();
        chk("R8 err cleared", int'(err), 0);
        sel = 3'b010; tick(); sel = 0;
        c2 = 1; upset = UW'(1) << 9; tick(); c2 = 0; upset = '0;
        chk("R8 err in wait", int'(err), 1);
        chk("R8 still waiting", int'(ph), 2);
        c2 = 1; c1 = 1; tick(); c2 = 0; c1 = 0;
        chk("R8 coffee delivered", int'(disp), 2);
        chk("R8 change", int'(chg), 1);
        exp_bill += 4;
        chk("R8 bill", int'(bill), exp_bill);
        tick();

        // R9: double flip breaks one-hot, forced selection, credit dropped
        sel = 3'b100; tick(); sel = 0;
        c1 = 1; upset = (UW'(1) << 1) | (UW'(1) << 5); tick(); c1 = 0; upset = '0;
        chk("R9 err", int'(err), 1);
        chk("R9 forced select", int'(ph), 1);
        c5 = 1; tick(); c5 = 0;
        chk("R9 no dispense", int'(disp), 0);
        chk("R9 err cleared", int'(err), 0);
        sel = 3'b100; tick(); sel = 0;
        c5 = 1; tick(); c5 = 0;
        chk("R9 credit discarded", int'(chg), 0);
        chk("R9 milk", int'(disp), 4);
        exp_bill += 5;
        tick();

        // R3: service lockout
        avail = 0; sel = 3'b001; tick(); sel = 0; avail = 1;
        chk("R3 service phase", int'(ph), 8);
        chk("R3 service flag", int'(svc), 1);
        sel = 3'b010; put_coins(7); cancel = 1; tick(); tick();
        idle_in();
        chk("R3 locked", int'(ph), 8);
        chk("R3 no outputs", int'({disp, rfd}), 0);
        chk("R7 bill held", int'(bill), exp_bill);
        do_reset();
        chk("R1 after reset", int'(ph), 1);
        chk("R7 bill cleared by reset", int'(bill), 0);

        // R4/R7 saturation on the large-price instance
        sel = 3'b100; tick(); sel = 0;
        for (int k = 0; k < 25; k++) begin
            c5 = 1; tick(); c5 = 0;
        end
        chk("R4 below price", int'(disp_b), 0);
        c5 = 1; cancel = 1; tick(); c5 = 0; cancel = 0;
        chk("R4 saturated refund", int'(rfd_b), 127);
        sel = 3'b100; tick(); sel = 0;
        for (int k = 0; k < 25; k++) begin
            c5 = 1; tick(); c5 = 0;
        end
        c5 = 1; tick(); c5 = 0;
        chk("R4 saturated sum vends milk", int'(disp_b), 4);
        chk("R4 change zero", int'(chg_b), 0);
        chk("R7 bill 127", int'(bill_b), 127);
        tick();
        sel = 3'b001; tick(); sel = 0;
        for (int k = 0; k < 20; k++) begin
            c5 = 1; tick(); c5 = 0;
        end
        chk("R5 tea at 100", int'(disp_b), 1);
        chk("R7 bill saturates", int'(bill_b), 127);
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule